// File: doc/BRIEF.md
# Byte-Lane Write Front End for a Flow-Through Synchronous SRAM

This block sits between a bus-side address generator and a synchronous SRAM array. On each rising clock edge it captures the chip select, the address, the write data and three levels of write control. These are a global write that forces every lane, a master byte-write enable, and one enable per byte lane. From them it decides whether the cycle is a write, a read or idle. Every byte lane is nine bits wide: eight data bits plus one parity bit. A write updates only the lanes its controls select.

Reads are flow-through. The stored word for the captured address appears on the read port during the cycle right after the capturing edge, with no further output register. A captured write completes on its own over the next edge, and its data is then kept in a one-entry write buffer. A read of the same address in the very next cycle takes the freshly written lanes from that buffer and the other lanes from the array. The output-enable tristate of a real device is represented by a valid flag.

Top module: `sbw_front`

## Requirements
- R1: All inputs are sampled on the rising edge. The `rdata`/`rvalid` result of a cycle captured at edge k is present during the clock period that follows edge k.
- R2: With `sel` high and `gw_n` low, all lanes are written whatever `bwe_n` and `bw_n` hold.
- R3: With `gw_n` high, the `bw_n` bits act only while `bwe_n` is low. With `gw_n` high and either `bwe_n` high or every `bw_n` bit high, the selected cycle is a read and changes no stored data.
- R4: Lane i occupies `wdata[9*i+8:9*i]` and `rdata[9*i+8:9*i]`, with the parity bit at position 9*i+8, and is enabled by the active-low bit `bw_n[i]`.
- R5: Lanes not enabled in a write keep their previous contents.
- R6: A read returns the word last written to that address, with `rvalid` high in its result cycle.
- R7: A read in the cycle right after a write to the same address returns the newly written lanes, with the unwritten lanes taken from storage.
- R8: A read in the cycle right after a write to a different address returns that address's stored word, with nothing forwarded.
- R9: With `sel` low, the cycle writes nothing and `rvalid` is low in its result cycle.
- R10: `rvalid` is low in the result cycle of a write.
- R11: While `rst` is high, and in the cycle after it, `rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Chip select, active high, captured on the edge |
| addr | input | ADDR_W | Word address from the external address generator |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Master byte-write enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| wdata | input | 9*LANES | Write data, nine bits per lane with parity in the top bit |
| rdata | output | 9*LANES | Read data for the captured address |
| rvalid | output | 1 | High when `rdata` carries the result of a read |

## Verification
The assertions assume that the control inputs are at defined levels at every edge. They also assume that `sel` stays low while reset is held. The forwarding property further assumes that `wdata` is steady for the whole cycle in which the write is captured. The bench changes inputs only on the falling edge, keeps `sel` low during reset, and drives every control bit to an explicit value on every cycle. As a result, each sampled edge sees one well-formed command.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    localparam int LANE_DATA_W = 8;
    localparam int LANE_W      = LANE_DATA_W + 1;
    localparam int MAX_LANES   = 8;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    // Two-level write qualification: global write forces every lane,
    // otherwise lane enables count only under the master enable.
    function automatic logic [MAX_LANES-1:0] lane_enables(
        input logic                 gw_n,
        input logic                 bwe_n,
        input logic [MAX_LANES-1:0] bw_n,
        input int                   lanes
    );
        logic [MAX_LANES-1:0] present;
        for (int i = 0; i < MAX_LANES; i++) begin
            present[i] = (i < lanes);
        end
        if (!gw_n) begin
            return present;
        end
        if (!bwe_n) begin
            return ~bw_n & present;
        end
        return '0;
    endfunction

    function automatic cyc_e classify(input logic sel, input logic any_lane);
        if (!sel) begin
            return CYC_IDLE;
        end
        return any_lane ? CYC_WRITE : CYC_READ;
    endfunction

endpackage

// File: rtl/sbw_capture.sv
module sbw_capture
    import sbw_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output cyc_e                    cyc_q,
    output logic [ADDR_W-1:0]       addr_q,
    output logic [LANES-1:0]        mask_q,
    output logic [LANES*LANE_W-1:0] data_q
);

    logic [MAX_LANES-1:0] bw_wide;
    logic [MAX_LANES-1:0] en_wide;
    logic [LANES-1:0]     en;
    cyc_e                 cyc_d;

    always_comb begin
        bw_wide            = '1;
        bw_wide[LANES-1:0] = bw_n;
        en_wide            = lane_enables(gw_n, bwe_n, bw_wide, LANES);
        en                 = en_wide[LANES-1:0];
        cyc_d              = classify(sel, |en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= CYC_IDLE;
            mask_q <= '0;
        end else begin
            cyc_q  <= cyc_d;
            mask_q <= (cyc_d == CYC_WRITE) ? en : '0;
        end
        addr_q <= addr;
        data_q <= wdata;
    end

endmodule

// File: rtl/sbw_array.sv
module sbw_array
    import sbw_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wmask,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/sbw_wbuf.sv
module sbw_wbuf
    import sbw_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  cyc_e                    cyc_q,
    input  logic [ADDR_W-1:0]       addr_q,
    input  logic [LANES-1:0]        mask_q,
    input  logic [LANES*LANE_W-1:0] data_q,
    input  logic [LANES*LANE_W-1:0] arr_rdata,
    output logic                    wb_vld,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [LANES-1:0]        wb_mask,
    output logic [LANES*LANE_W-1:0] wb_data,
    output logic [LANES*LANE_W-1:0] merged
);

    logic hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_vld  <= 1'b0;
            wb_mask <= '0;
        end else begin
            wb_vld  <= (cyc_q == CYC_WRITE);
            wb_mask <= mask_q;
        end
        wb_addr <= addr_q;
        wb_data <= data_q;
    end

    assign hit = wb_vld && (wb_addr == addr_q);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign merged[g*LANE_W +: LANE_W] = (hit && wb_mask[g])
                                          ? wb_data[g*LANE_W +: LANE_W]
                                          : arr_rdata[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/sbw_front.sv
module sbw_front
    import sbw_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DATA_W = LANES * LANE_W;

    cyc_e              cyc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] arr_rdata;
    logic              wb_vld;
    logic [ADDR_W-1:0] wb_addr;
    logic [LANES-1:0]  wb_mask;
    logic [DATA_W-1:0] wb_data;

    sbw_capture #(.LANES(LANES), .ADDR_W(ADDR_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .addr   (addr),
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .bw_n   (bw_n),
        .wdata  (wdata),
        .cyc_q  (cyc_q),
        .addr_q (addr_q),
        .mask_q (mask_q),
        .data_q (data_q)
    );

    sbw_array #(.LANES(LANES), .ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .we    (wb_vld),
        .waddr (wb_addr),
        .wmask (wb_mask),
        .wdata (wb_data),
        .raddr (addr_q),
        .rdata (arr_rdata)
    );

    sbw_wbuf #(.LANES(LANES), .ADDR_W(ADDR_W)) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .cyc_q     (cyc_q),
        .addr_q    (addr_q),
        .mask_q    (mask_q),
        .data_q    (data_q),
        .arr_rdata (arr_rdata),
        .wb_vld    (wb_vld),
        .wb_addr   (wb_addr),
        .wb_mask   (wb_mask),
        .wb_data   (wb_data),
        .merged    (rdata)
    );

    assign rvalid = (cyc_q == CYC_READ);

endmodule

// File: rtl/sbw_front_chk.sv
module sbw_front_chk
    import sbw_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    sel,
    input logic [ADDR_W-1:0]       addr,
    input logic                    gw_n,
    input logic                    bwe_n,
    input logic [LANES-1:0]        bw_n,
    input logic [LANES*LANE_W-1:0] wdata,
    input logic [LANES*LANE_W-1:0] rdata,
    input logic                    rvalid
);

    logic wr_req;
    logic rd_req;

    assign wr_req = sel && (!gw_n || (!bwe_n && !(&bw_n)));
    assign rd_req = sel && gw_n && (bwe_n || (&bw_n));

    p_reset_quiet_r11: assert property (@(posedge clk)
        rst |=> !rvalid);

    p_desel_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !rvalid);

    p_write_hides_r10: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !rvalid);

    p_read_flags_r6: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rvalid);

    // R7 / R2: full-word write followed at once by a read of that address
    p_full_passthru_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !$past(rst) && $past(sel) && !$past(gw_n) && ($past(addr) == addr))
        |=> (rdata == $past(wdata, 2)));

endmodule

bind sbw_front sbw_front_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .addr   (addr),
    .gw_n   (gw_n),
    .bwe_n  (bwe_n),
    .bw_n   (bw_n),
    .wdata  (wdata),
    .rdata  (rdata),
    .rvalid (rvalid)
);

// File: tb/sbw_front_test.sv
module sbw_front_test;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = LANES * 9;

    logic              clk = 1'b0;
    logic              rst;
    logic              sel;
    logic [ADDR_W-1:0] addr;
    logic              gw_n;
    logic              bwe_n;
    logic [LANES-1:0]  bw_n;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              rvalid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [DATA_W-1:0] model [1 << ADDR_W];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sbw_front #(.LANES(LANES), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .sel(sel), .addr(addr), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string req, input string what,
                         input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, capture on the rising edge,
    // check the flow-through result at the next falling edge (R1).
    task automatic cycle(input string req, input logic s, input logic [ADDR_W-1:0] a,
                         input logic g, input logic be, input logic [LANES-1:0] b,
                         input logic [DATA_W-1:0] d);
        logic [LANES-1:0]  lanes;
        logic              exp_valid;
        logic [DATA_W-1:0] exp_data;
        sel = s; addr = a; gw_n = g; bwe_n = be; bw_n = b; wdata = d;
        if (!g)       lanes = '1;
        else if (!be) lanes = ~b;
        else          lanes = '0;
        exp_valid = s && (lanes == '0);
        if (s) begin
            for (int i = 0; i < LANES; i++) begin
                if (lanes[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
            end
        end
        exp_data = model[a];
        @(posedge clk);
        @(negedge clk);
        check(req, "rvalid", DATA_W'(rvalid), DATA_W'(exp_valid));
        if (exp_valid) check(req, "rdata", rdata, exp_data);
    endtask

    function automatic logic [DATA_W-1:0] pat(input int seed);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < LANES; i++) begin
            v[i*9 +: 9] = 9'((seed * 37 + i * 101 + 5) % 512);
        end
        return v;
    endfunction

    task automatic t_reset;
        rst = 1'b1; sel = 1'b0; addr = '0; gw_n = 1'b1; bwe_n = 1'b1;
        bw_n = '1; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "rvalid in reset", DATA_W'(rvalid), '0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R11", "rvalid after reset", DATA_W'(rvalid), '0);
    endtask

    // R2/R10: global write ignores bwe_n/bw_n; R6 readback later
    task automatic t_global;
        for (int k = 0; k < 16; k++) begin
            cycle("R2", 1'b1, ADDR_W'(k), 1'b0, k[0], LANES'(k), pat(k));
        end
        cycle("R10", 1'b1, 8'd40, 1'b0, 1'b1, '1, pat(99));
        for (int k = 0; k < 16; k++) begin
            cycle("R6", 1'b1, ADDR_W'(k), 1'b1, 1'b1, '0, '0);
        end
        cycle("R6", 1'b1, 8'd40, 1'b1, 1'b1, '0, '0);
    endtask

    // R4/R5/R7: single-lane writes, each read right after, parity bit set
    task automatic t_lanes;
        for (int i = 0; i < LANES; i++) begin
            logic [DATA_W-1:0] d = '0;
            d[i*9 +: 9] = 9'h100 | 9'(8'hA0 + i);
            cycle("R4", 1'b1, 8'd3, 1'b1, 1'b0, ~(LANES'(1) << i), d);
            cycle("R7", 1'b1, 8'd3, 1'b1, 1'b1, '1, '0);
        end
    endtask

    // R5/R7: two-lane write, read at once, then back-to-back writes
    task automatic t_partial;
        cycle("R5", 1'b1, 8'd5, 1'b1, 1'b0, 4'b1010, pat(300));
        cycle("R7", 1'b1, 8'd5, 1'b1, 1'b0, 4'b1111, '0);
        cycle("R5", 1'b1, 8'd6, 1'b1, 1'b0, 4'b0111, pat(301));
        cycle("R5", 1'b1, 8'd6, 1'b1, 1'b0, 4'b1110, pat(302));
        cycle("R7", 1'b1, 8'd6, 1'b1, 1'b1, 4'b0000, '0);
        cycle("R5", 1'b1, 8'd6, 1'b1, 1'b1, 4'b0000, '0);
    endtask

    // R3: bw_n ignored without bwe_n low; all-high lane enables read
    task automatic t_master;
        cycle("R3", 1'b1, 8'd7, 1'b1, 1'b1, 4'b0000, pat(400));
        cycle("R3", 1'b1, 8'd7, 1'b1, 1'b0, 4'b1111, pat(401));
        cycle("R3", 1'b1, 8'd7, 1'b1, 1'b1, 4'b0000, '0);
    endtask

    // R9: deselected global write leaves storage untouched
    task automatic t_desel;
        cycle("R9", 1'b0, 8'd8, 1'b0, 1'b0, 4'b0000, pat(500));
        cycle("R9", 1'b1, 8'd8, 1'b1, 1'b1, 4'b0000, '0);
        cycle("R9", 1'b0, 8'd9, 1'b1, 1'b1, 4'b1111, '0);
    endtask

    // R8: write then read of another address; R6 original address later
    task automatic t_other;
        cycle("R8", 1'b1, 8'd10, 1'b0, 1'b1, '1, pat(600));
        cycle("R8", 1'b1, 8'd11, 1'b1, 1'b1, '1, '0);
        cycle("R8", 1'b1, 8'd12, 1'b1, 1'b0, 4'b0110, pat(601));
        cycle("R8", 1'b1, 8'd13, 1'b1, 1'b1, '1, '0);
        cycle("R6", 1'b1, 8'd10, 1'b1, 1'b1, '1, '0);
        cycle("R6", 1'b1, 8'd12, 1'b1, 1'b1, '1, '0);
    endtask

    // R2/R7: full global write followed at once by read
    task automatic t_passthru;
        cycle("R2", 1'b1, 8'd14, 1'b0, 1'b0, 4'b1010, pat(700));
        cycle("R7", 1'b1, 8'd14, 1'b1, 1'b1, '1, '0);
    endtask

    initial begin
        t_reset();
        t_global();
        t_lanes();
        t_partial();
        t_master();
        t_desel();
        t_other();
        t_passthru();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule